// File: doc/BRIEF.md
# PCIe power-on reset sequencer

This block takes a PCIe controller and its PHY out of reset after power-on. It releases them one domain at a time and waits a fixed time at each step. Once software or a power manager pulses `start`, the sequencer holds the slot reset low and sets reset-control bits in a fixed order. These bits only accumulate and are never cleared. Each wait is counted in clock cycles derived from `CLK_FREQ_HZ`. `SIM_DIV` divides every wait so that a simulation stays short.

After the primary-interface step, the block fixes up each lane's receiver control register through a small register port. For each lane it issues a read, takes the returned word, clears the mixer-load field, and writes the word back. It starts with lane 0 and moves to the next lane only after the write is accepted. It then raises `done`.

Configuration accesses from upstream pass through a gate. Until `done` is high, the controller is treated as absent: every access is accepted at once and answered with an error pulse, and nothing is forwarded. Once `done` is high, the gate is a plain valid/ready wire between the two sides.

Back-pressure follows the usual valid/ready rules:
- A request is held stable while `req_valid` is high and `req_ready` is low.
- A transfer happens on a clock edge where both are high.
- The sequencer waits for any handshake without a time limit.
- On the read return, `rd_ready` is high only while a read result is awaited.

Top module: `pcie_rst_seq`

## Requirements
- R1: After a synchronous `rst`, and while idle:
  - `perst_n` is 0, `rst_ctl` is 0, `done` is 0 and `busy` is 0;
  - a `start` sampled high in idle launches the sequence.
- R2: In the cycle after `start` is accepted, `busy` is 1, `perst_n` is still 0 and `rst_ctl` is still 0. In the following cycle `rst_ctl` becomes 5'b00001.
  - The bits of `rst_ctl` are: bit0 PHY common lane, bit1 PHY sideband, bit2 controller main, bit3 controller sideband, bit4 controller primary.
- R3: Each wait lasts D(ms) = max(1, (CLK_FREQ_HZ/1000)*ms/SIM_DIV) cycles.
  - `rst_ctl` stays 5'b00001 for D(1) cycles.
  - It then becomes 5'b00111, with bit1 and bit2 set in the same cycle, and stays so for D(80) cycles.
  - It then becomes 5'b01111 for D(20) cycles.
- R4: Outside reset, no bit of `rst_ctl` ever changes from 1 to 0.
- R5: `perst_n` rises to 1 when the D(20) wait ends, while `rst_ctl` is 5'b01111. Bit4 is set one cycle later, and bit4 is never 1 while `perst_n` is 0.
- R6: Register requests and the read return each complete only on a valid/ready handshake.
  - While `req_valid` is high and `req_ready` is low, `req_we`, `req_addr` and `req_wdata` are held.
  - The sequencer stalls indefinitely until the handshake.
- R7: For each lane i, starting with lane 0, the sequencer issues two requests at address LANE_BASE + i*LANE_STRIDE:
  - first a read (`req_we`=0), taking the `rd_data` presented while `rd_valid` and `rd_ready` are both high;
  - then a write (`req_we`=1) of that word with bits 6 and 7 cleared and all other bits kept.
  - The first read request appears in the same cycle that bit4 is set.
- R8: `done` rises in the cycle after the last lane's write handshake, with `busy` falling at the same time. `done` then stays 1 until `rst`.
- R9: While `done` is 0, a configuration access is refused without being forwarded:
  - `cfg_in_ready` is 1 and `cfg_out_valid` is 0;
  - `cfg_err` equals `cfg_in_valid` in the same cycle.
- R10: While `done` is 1:
  - `cfg_out_valid` follows `cfg_in_valid`, and `cfg_out_data` follows `cfg_in_data`;
  - `cfg_in_ready` follows `cfg_out_ready`;
  - `cfg_err` is 0.
- R11: A `start` pulse while the sequence is running, or after `done`, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the sequence when idle |
| perst_n | output | 1 | Slot reset, low while asserted |
| rst_ctl | output | 5 | Accumulated reset-control bits (bit0 PHY lane, bit1 PHY sideband, bit2 controller main, bit3 controller sideband, bit4 controller primary) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, controller present |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request accepted |
| req_we | output | 1 | 1 for write, 0 for read |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | DATA_W | Write data |
| rd_valid | input | 1 | Read data valid |
| rd_ready | output | 1 | Sequencer waiting for read data |
| rd_data | input | DATA_W | Read data |
| cfg_in_valid | input | 1 | Upstream configuration access valid |
| cfg_in_ready | output | 1 | Upstream access accepted |
| cfg_in_data | input | CFG_W | Upstream access payload |
| cfg_err | output | 1 | Error response for a refused access |
| cfg_out_valid | output | 1 | Forwarded access valid |
| cfg_out_ready | input | 1 | Controller accepts forwarded access |
| cfg_out_data | output | CFG_W | Forwarded access payload |

## Verification
The assertions assume the following of the inputs:
- `rst` is high at time zero and synchronous to `clk`;
- the register responder eventually raises `req_ready` and `rd_valid`;
- all inputs change only between clock edges.

The stimulus keeps to these assumptions. Inputs are driven just after the falling edge. The responder's ready and valid are either held high or drawn at random, with a one-in-four chance of being high in any cycle, so every stall is finite. `rd_data` is a fresh random word each cycle, which exercises the bit-6/7 clearing against arbitrary neighbouring bits. Upstream configuration traffic and downstream readiness are random throughout, both before and after `done`.

// File: rtl/pcie_rst_seq_pkg.sv
package pcie_rst_seq_pkg;

  localparam int CTL_W = 5;

  localparam logic [CTL_W-1:0] CTL_PHY_LANE = 5'b00001;
  localparam logic [CTL_W-1:0] CTL_PHY_SB   = 5'b00010;
  localparam logic [CTL_W-1:0] CTL_MAIN     = 5'b00100;
  localparam logic [CTL_W-1:0] CTL_CTRL_SB  = 5'b01000;
  localparam logic [CTL_W-1:0] CTL_PRI      = 5'b10000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PERST,
    ST_WAIT_LANE,
    ST_WAIT_PLL,
    ST_WAIT_CSB,
    ST_RELEASE,
    ST_PRI,
    ST_RMW,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    RMW_IDLE,
    RMW_RD,
    RMW_RDW,
    RMW_WR
  } rmw_state_e;

  function automatic int ms_cycles(longint hz, int ms, int div);
    longint c;
    c = (hz / 1000) * ms / div;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rst_seq_lane_rmw.sv
module rst_seq_lane_rmw
  import pcie_rst_seq_pkg::*;
#(
  parameter int          NUM_LANES   = 2,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          LANE_BASE   = 'h40,
  parameter int          LANE_STRIDE = 'h4,
  parameter logic [DATA_W-1:0] CLR_MASK = 'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              fin,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  rmw_state_e        st;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] word;
  logic [ADDR_W-1:0] lane_addr [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_addr[g] = ADDR_W'(LANE_BASE + g * LANE_STRIDE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RMW_IDLE;
      lane <= '0;
      word <= '0;
    end else begin
      case (st)
        RMW_IDLE: if (go) begin
          st   <= RMW_RD;
          lane <= '0;
        end
        RMW_RD: if (req_ready) st <= RMW_RDW;
        RMW_RDW: if (rd_valid) begin
          word <= rd_data & ~CLR_MASK;
          st   <= RMW_WR;
        end
        RMW_WR: if (req_ready) begin
          if (lane == LAST_LANE) begin
            st <= RMW_IDLE;
          end else begin
            lane <= lane + LANE_W'(1);
            st   <= RMW_RD;
          end
        end
        default: st <= RMW_IDLE;
      endcase
    end
  end

  assign req_valid = (st == RMW_RD) || (st == RMW_WR);
  assign req_we    = (st == RMW_WR);
  assign req_addr  = lane_addr[lane];
  assign req_wdata = word;
  assign rd_ready  = (st == RMW_RDW);
  assign fin       = (st == RMW_WR) && req_ready && (lane == LAST_LANE);
endmodule

// File: rtl/rst_seq_cfg_gate.sv
module rst_seq_cfg_gate #(
  parameter int CFG_W = 32
) (
  input  logic             open,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CFG_W-1:0] in_data,
  output logic             err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CFG_W-1:0] out_data
);
  assign out_valid = open && in_valid;
  assign in_ready  = open ? out_ready : 1'b1;
  assign err       = !open && in_valid;
  assign out_data  = in_data;
endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
  import pcie_rst_seq_pkg::*;
#(
  parameter longint CLK_FREQ_HZ = 125_000_000,
  parameter int     SIM_DIV     = 1,
  parameter int     NUM_LANES   = 2,
  parameter int     ADDR_W      = 16,
  parameter int     DATA_W      = 32,
  parameter int     CFG_W       = 32,
  parameter int     LANE_BASE   = 'h40,
  parameter int     LANE_STRIDE = 'h4,
  parameter int     MASK_LSB    = 6,
  parameter int     MASK_WIDTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              perst_n,
  output logic [CTL_W-1:0]  rst_ctl,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              cfg_in_valid,
  output logic              cfg_in_ready,
  input  logic [CFG_W-1:0]  cfg_in_data,
  output logic              cfg_err,
  output logic              cfg_out_valid,
  input  logic              cfg_out_ready,
  output logic [CFG_W-1:0]  cfg_out_data
);
  localparam int D_LANE = ms_cycles(CLK_FREQ_HZ, 1, SIM_DIV);
  localparam int D_PLL  = ms_cycles(CLK_FREQ_HZ, 80, SIM_DIV);
  localparam int D_CSB  = ms_cycles(CLK_FREQ_HZ, 20, SIM_DIV);
  localparam int D_MAX  = (D_PLL > D_CSB) ? ((D_PLL > D_LANE) ? D_PLL : D_LANE)
                                          : ((D_CSB > D_LANE) ? D_CSB : D_LANE);
  localparam int CNT_W  = $clog2(D_MAX + 1);
  localparam logic [DATA_W-1:0] CLR_MASK =
    DATA_W'(((1 << MASK_WIDTH) - 1) << MASK_LSB);

  seq_state_e       state;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             rmw_fin;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(D_LANE);
    case (state)
      ST_PERST:     tmr_load = 1'b1;
      ST_WAIT_LANE: begin tmr_load = tmr_done; tmr_val = CNT_W'(D_PLL); end
      ST_WAIT_PLL:  begin tmr_load = tmr_done; tmr_val = CNT_W'(D_CSB); end
      default:      ;
    endcase
  end

  rst_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      perst_n <= 1'b0;
      rst_ctl <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_PERST;
        ST_PERST: begin
          perst_n <= 1'b0;
          rst_ctl <= rst_ctl | CTL_PHY_LANE;
          state   <= ST_WAIT_LANE;
        end
        ST_WAIT_LANE: if (tmr_done) begin
          rst_ctl <= rst_ctl | CTL_PHY_SB | CTL_MAIN;
          state   <= ST_WAIT_PLL;
        end
        ST_WAIT_PLL: if (tmr_done) begin
          rst_ctl <= rst_ctl | CTL_CTRL_SB;
          state   <= ST_WAIT_CSB;
        end
        ST_WAIT_CSB: if (tmr_done) begin
          perst_n <= 1'b1;
          state   <= ST_RELEASE;
        end
        ST_RELEASE: begin
          rst_ctl <= rst_ctl | CTL_PRI;
          state   <= ST_RMW;
        end
        ST_RMW:  if (rmw_fin) state <= ST_DONE;
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done = (state == ST_DONE);
  assign busy = (state != ST_IDLE) && (state != ST_DONE);

  rst_seq_lane_rmw #(
    .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LANE_BASE(LANE_BASE), .LANE_STRIDE(LANE_STRIDE), .CLR_MASK(CLR_MASK)
  ) u_rmw (
    .clk(clk), .rst(rst), .go(state == ST_RELEASE), .fin(rmw_fin),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  rst_seq_cfg_gate #(.CFG_W(CFG_W)) u_gate (
    .open(done), .in_valid(cfg_in_valid), .in_ready(cfg_in_ready),
    .in_data(cfg_in_data), .err(cfg_err), .out_valid(cfg_out_valid),
    .out_ready(cfg_out_ready), .out_data(cfg_out_data)
  );
endmodule

// File: rtl/pcie_rst_seq_chk.sv
module pcie_rst_seq_chk
  import pcie_rst_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MASK_LSB   = 6,
  parameter int MASK_WIDTH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              perst_n,
  input logic [CTL_W-1:0]  rst_ctl,
  input logic              busy,
  input logic              done,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [DATA_W-1:0] req_wdata,
  input logic              cfg_in_valid,
  input logic              cfg_in_ready,
  input logic              cfg_err,
  input logic              cfg_out_valid,
  input logic              cfg_out_ready
);
  localparam logic [DATA_W-1:0] CLR_MASK =
    DATA_W'(((1 << MASK_WIDTH) - 1) << MASK_LSB);

  // R1: idle outputs
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (!perst_n && rst_ctl == '0));

  p_lane_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_ctl[0]) |-> (!perst_n && $past(!perst_n) && rst_ctl == 5'b00001));

  p_pll_pair_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_ctl[1]) |-> ($rose(rst_ctl[2]) && rst_ctl[0]));

  p_ctl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(rst_ctl) & ~rst_ctl) == '0));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(perst_n) |-> (rst_ctl == 5'b01111));

  p_pri_late_r5: assert property (@(posedge clk) disable iff (rst)
    rst_ctl[4] |-> perst_n);

  p_req_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_we) && $stable(req_wdata)));

  p_wr_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we) |-> ((req_wdata & CLR_MASK) == '0));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_done_final_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && perst_n && (&rst_ctl)));

  p_gate_closed_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_in_valid && !done) |-> (cfg_err && !cfg_out_valid && cfg_in_ready));

  p_gate_open_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cfg_err && cfg_in_ready == cfg_out_ready));
endmodule

bind pcie_rst_seq pcie_rst_seq_chk #(
  .DATA_W(DATA_W), .MASK_LSB(MASK_LSB), .MASK_WIDTH(MASK_WIDTH)
) u_chk (
  .clk(clk), .rst(rst), .perst_n(perst_n), .rst_ctl(rst_ctl),
  .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_wdata(req_wdata), .cfg_in_valid(cfg_in_valid),
  .cfg_in_ready(cfg_in_ready), .cfg_err(cfg_err),
  .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready)
);

// File: tb/test_pcie_rst_seq.sv
module test_pcie_rst_seq;
  localparam longint HZ = 125_000_000;
  localparam int DIV    = 10_000;
  localparam int AW = 16, DW = 32, CW = 32;
  localparam int LBASE = 'h40, LSTRIDE = 'h4;
  localparam logic [31:0] MASK = 32'h0000_00C0;
  localparam int WDOG = 100_000;

  function automatic int wait_cyc(int ms);
    longint c;
    c = (HZ / 1000) * ms / DIV;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int M_IDLE = 0, M_PERST = 1, M_W1 = 2, M_W80 = 3, M_W20 = 4,
                 M_REL = 5, M_RD = 6, M_RDW = 7, M_WR = 8, M_DONE = 9;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0;
  logic perst_n, busy, done;
  logic [4:0] rst_ctl;
  logic req_valid, req_ready = 1'b0, req_we, rd_valid = 1'b0, rd_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rd_data = '0;
  logic cfg_in_valid = 1'b0, cfg_in_ready, cfg_err, cfg_out_valid, cfg_out_ready = 1'b0;
  logic [CW-1:0] cfg_in_data = '0, cfg_out_data;

  always #4 clk = ~clk;

  pcie_rst_seq #(
    .CLK_FREQ_HZ(HZ), .SIM_DIV(DIV), .NUM_LANES(2), .ADDR_W(AW), .DATA_W(DW),
    .CFG_W(CW), .LANE_BASE(LBASE), .LANE_STRIDE(LSTRIDE), .MASK_LSB(6), .MASK_WIDTH(2)
  ) i_pcie_rst_seq (
    .clk(clk), .rst(rst), .start(start), .perst_n(perst_n), .rst_ctl(rst_ctl),
    .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cfg_in_valid(cfg_in_valid), .cfg_in_ready(cfg_in_ready), .cfg_in_data(cfg_in_data),
    .cfg_err(cfg_err), .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
    .cfg_out_data(cfg_out_data)
  );

  // behavioural reference model, advanced on every rising edge from bench-driven inputs
  int m_st = M_IDLE, m_cnt = 0, m_lane = 0;
  logic m_perst_n = 1'b0;
  logic [4:0] m_ctl = '0;
  logic [31:0] m_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = M_IDLE; m_ctl = '0; m_perst_n = 1'b0; m_lane = 0; m_cnt = 0;
    end else begin
      case (m_st)
        M_IDLE:  if (start) m_st = M_PERST;
        M_PERST: begin m_ctl = 5'b00001; m_cnt = wait_cyc(1); m_st = M_W1; end
        M_W1: begin
          m_cnt--;
          if (m_cnt == 0) begin m_ctl = 5'b00111; m_cnt = wait_cyc(80); m_st = M_W80; end
        end
        M_W80: begin
          m_cnt--;
          if (m_cnt == 0) begin m_ctl = 5'b01111; m_cnt = wait_cyc(20); m_st = M_W20; end
        end
        M_W20: begin
          m_cnt--;
          if (m_cnt == 0) begin m_perst_n = 1'b1; m_st = M_REL; end
        end
        M_REL: begin m_ctl = 5'b11111; m_lane = 0; m_st = M_RD; end
        M_RD:  if (req_ready) m_st = M_RDW;
        M_RDW: if (rd_valid) begin m_data = rd_data; m_st = M_WR; end
        M_WR:  if (req_ready) begin
          if (m_lane == 1) m_st = M_DONE;
          else begin m_lane++; m_st = M_RD; end
        end
        default: ;
      endcase
    end
  end

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic nxt_rst = 1'b1, nxt_start = 1'b0, stall = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    logic open, ev;
    open = (m_st == M_DONE);
    ev   = (m_st == M_RD) || (m_st == M_WR);
    chk("R2/R5 perst_n", perst_n, m_perst_n);
    chk("R3/R4 rst_ctl", rst_ctl, m_ctl);
    chk("R8 done", done, open);
    chk("R8/R11 busy", busy, (m_st != M_IDLE) && !open);
    chk("R6/R7 req_valid", req_valid, ev);
    if (ev) begin
      chk("R7 req_we", req_we, m_st == M_WR);
      chk("R7 req_addr", req_addr, AW'(LBASE + m_lane * LSTRIDE));
      if (m_st == M_WR) chk("R7 req_wdata", req_wdata, m_data & ~MASK);
    end
    chk("R6 rd_ready", rd_ready, m_st == M_RDW);
    chk("R9/R10 cfg_in_ready", cfg_in_ready, open ? cfg_out_ready : 1'b1);
    chk("R9 cfg_err", cfg_err, cfg_in_valid && !open);
    chk("R9/R10 cfg_out_valid", cfg_out_valid, cfg_in_valid && open);
    if (open && cfg_in_valid) chk("R10 cfg_out_data", cfg_out_data, cfg_in_data);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
    cyc++;
    if (cyc > WDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WDOG);
      summary();
      $finish;
    end
    #1;
    rst           = nxt_rst;
    start         = nxt_start;
    req_ready     = stall ? ($urandom_range(0, 3) == 0) : 1'b1;
    rd_valid      = stall ? ($urandom_range(0, 3) == 0) : 1'b1;
    rd_data       = $urandom;
    cfg_in_valid  = $urandom_range(0, 1) == 1;
    cfg_in_data   = $urandom;
    cfg_out_ready = $urandom_range(0, 1) == 1;
  endtask

  task automatic do_reset();
    nxt_rst = 1'b1; nxt_start = 1'b0;
    repeat (3) cycle();
    nxt_rst = 1'b0;
    repeat (2) cycle();
    // R1: explicit idle state check
    chk("R1 idle perst_n", perst_n, 1'b0);
    chk("R1 idle rst_ctl", rst_ctl, 5'b0);
    chk("R1 idle done", done, 1'b0);
    chk("R1 idle busy", busy, 1'b0);
  endtask

  task automatic pulse_start();
    nxt_start = 1'b1; cycle(); nxt_start = 1'b0;
  endtask

  task automatic run_to_done(int stray_at);
    int k = 0;
    while (m_st != M_DONE) begin
      nxt_start = (k == stray_at);  // R11: stray start while running
      cycle();
      k++;
    end
    nxt_start = 1'b0;
  endtask

  initial begin
    do_reset();
    repeat (10) cycle();                 // R9 traffic while idle
    stall = 1'b0;
    pulse_start();
    run_to_done(200);
    repeat (20) cycle();                 // R10 pass-through
    pulse_start();                       // R11: start after done
    repeat (20) cycle();
    chk("R11 done held", done, 1'b1);

    do_reset();
    stall = 1'b1;
    pulse_start();
    run_to_done(700);
    repeat (30) cycle();

    do_reset();
    pulse_start();
    while (m_st != M_W80) cycle();
    repeat (50) cycle();
    do_reset();                          // R1: reset mid-sequence
    pulse_start();
    run_to_done(-1);
    repeat (20) cycle();
    chk("R8 final rst_ctl", rst_ctl, 5'b11111);

    summary();
    $finish;
  end
endmodule